// File: doc/BRIEF.md
# MDIO Management Write Frame Master

This block drives one management write transaction onto a two-wire serial management pair: a clock line and a shared bidirectional data line, the latter split into an output value and an output-enable for an external tri-state pad. A single-cycle start request supplies a 5-bit PHY address, a 5-bit register number and a 16-bit write value. The block then sends a complete frame: a run of ones for synchronisation, start and write codes, the two address fields, a two-bit turnaround with the line released, the data word, and one more released bit.

Every bit time has two equal phases, each `HALF_DIV` system clocks long. In the first phase the management clock is low and the bit is presented. In the second phase the clock is high. On the edge that raises the clock, the block samples the incoming data line into a capture register. Once the last bit is done, the clock and data outputs are low and the driver is off. The capture register then holds the 65 sampled bits until the next frame starts.

Top module: `mdio_wr_master`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `mdc_o`, `mdio_out_o` and `mdio_oe_o` are 0. After reset, `capture_o` is all zeros.
- R2: Frame bits 0 to 31 are driven as 1 (`mdio_oe_o`=1, `mdio_out_o`=1).
- R3: Frame bits 32 to 35 are driven as the sequence 0, 1, 0, 1: start code, then write code.
- R4: Bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register number, each sent MSB first and driven.
- R5: Bits 46 and 47 are turnaround bits with `mdio_oe_o`=0 and `mdio_out_o`=0.
- R6: Bits 48 to 63 carry the 16-bit write value, MSB first and driven.
- R7: Bit 64 is sent with the driver off. A frame has exactly 65 rising edges of `mdc_o`.
- R8: Each clock phase lasts exactly `HALF_DIV` system clocks, so `busy_o` stays high for 130*`HALF_DIV` cycles. `mdio_out_o` and `mdio_oe_o` do not change while `mdc_o` is high.
- R9: `start_i` is accepted only while `busy_o` is low. `busy_o` rises on the cycle after acceptance. A start request during a frame changes neither the frame content nor its length.
- R10: On each clock edge where `mdc_o` rises, `mdio_in_i` is sampled. The sample taken in frame bit i lands in `capture_o[64-i]`. The register holds its value after the frame until the next accepted start.
- R11: `mdio_out_o` is 0 whenever `mdio_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle frame request |
| phy_addr_i | input | 5 | PHY address, latched when a start is accepted |
| reg_addr_i | input | 5 | Register number, latched when a start is accepted |
| wdata_i | input | 16 | Write value, latched when a start is accepted |
| mdio_in_i | input | 1 | Input side of the data line |
| mdc_o | output | 1 | Management clock |
| mdio_out_o | output | 1 | Output value for the data line |
| mdio_oe_o | output | 1 | Output-enable for the data line driver |
| busy_o | output | 1 | High while a frame is in progress |
| capture_o | output | 65 | Samples of the data line taken on the rising clock edges |

## Verification
Two things can fall on the same clock edge: the rise of the management clock, which shifts a sample into the capture register, and the bench changing the input line for the next bit. The bench changes `mdio_in_i` only at the falling system edge just after it sees `mdc_o` rise. Each bit therefore gets its own pattern value, and the whole 65-bit capture is compared with the pattern. A second overlap is a start request that arrives in the middle of a frame. The bench injects one at bit 10 with different field values. It then checks that every remaining bit, the busy length and the edge count still match the first request.

// File: rtl/mdio_wr_pkg.sv
package mdio_wr_pkg;

    localparam int FRAME_BITS = 65;
    localparam int IDX_W      = 7;
    localparam int POS_START  = 32;
    localparam int POS_PHY    = 36;
    localparam int POS_REG    = 41;
    localparam int POS_TA     = 46;
    localparam int POS_DATA   = 48;
    localparam int POS_LAST   = 64;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] data;
    } wr_cmd_t;

    typedef struct packed {
        logic oe;
        logic val;
    } line_t;

    // Line state for one bit position of a write frame
    function automatic line_t frame_line(input logic [IDX_W-1:0] idx, input wr_cmd_t c);
        line_t l;
        int    i;
        i = int'(idx);
        l = '0;
        if (i < POS_START) begin
            l.oe  = 1'b1;
            l.val = 1'b1;
        end else if (i < POS_PHY) begin
            l.oe  = 1'b1;
            l.val = idx[0];
        end else if (i < POS_REG) begin
            l.oe  = 1'b1;
            l.val = c.phy[3'(POS_REG - 1 - i)];
        end else if (i < POS_TA) begin
            l.oe  = 1'b1;
            l.val = c.regn[3'(POS_TA - 1 - i)];
        end else if (i < POS_DATA) begin
            l = '0;
        end else if (i < POS_LAST) begin
            l.oe  = 1'b1;
            l.val = c.data[4'(POS_LAST - 1 - i)];
        end else begin
            l = '0;
        end
        return l;
    endfunction

endpackage

// File: rtl/mdio_phase_timer.sv
module mdio_phase_timer #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_wr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  wr_cmd_t          cmd_in,
    input  logic             tick,
    output logic             busy,
    output phase_e           phase,
    output logic [IDX_W-1:0] bit_idx,
    output wr_cmd_t          cmd_q,
    output logic             rise_stb
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    assign rise_stb = busy && tick && (phase == PH_LOW);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            phase   <= PH_LOW;
            bit_idx <= '0;
            cmd_q   <= '0;
        end else if (!busy) begin
            if (start) begin
                busy    <= 1'b1;
                phase   <= PH_LOW;
                bit_idx <= '0;
                cmd_q   <= cmd_in;
            end
        end else if (tick) begin
            if (phase == PH_LOW) begin
                phase <= PH_HIGH;
            end else if (bit_idx == LAST_IDX) begin
                busy    <= 1'b0;
                phase   <= PH_LOW;
                bit_idx <= '0;
            end else begin
                phase   <= PH_LOW;
                bit_idx <= bit_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
    parameter int WIDTH = 65
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             din,
    output logic [WIDTH-1:0] cap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else if (stb) begin
            cap <= {cap[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_wr_master.sv
module mdio_wr_master
    import mdio_wr_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [4:0]            phy_addr_i,
    input  logic [4:0]            reg_addr_i,
    input  logic [15:0]           wdata_i,
    input  logic                  mdio_in_i,
    output logic                  mdc_o,
    output logic                  mdio_out_o,
    output logic                  mdio_oe_o,
    output logic                  busy_o,
    output logic [FRAME_BITS-1:0] capture_o
);
    wr_cmd_t          cmd_in;
    wr_cmd_t          cmd_q;
    logic             busy;
    logic             tick;
    logic             rise_stb;
    phase_e           phase;
    logic [IDX_W-1:0] bit_idx;
    line_t            line;

    assign cmd_in = '{phy: phy_addr_i, regn: reg_addr_i, data: wdata_i};

    mdio_phase_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .cmd_in   (cmd_in),
        .tick     (tick),
        .busy     (busy),
        .phase    (phase),
        .bit_idx  (bit_idx),
        .cmd_q    (cmd_q),
        .rise_stb (rise_stb)
    );

    mdio_capture #(.WIDTH(FRAME_BITS)) u_cap (
        .clk (clk),
        .rst (rst),
        .stb (rise_stb),
        .din (mdio_in_i),
        .cap (capture_o)
    );

    always_comb begin
        line = busy ? frame_line(bit_idx, cmd_q) : '0;
    end

    assign mdc_o      = busy && (phase == PH_HIGH);
    assign mdio_oe_o  = line.oe;
    assign mdio_out_o = line.val;
    assign busy_o     = busy;
endmodule

// File: rtl/mdio_wr_checker.sv
module mdio_wr_checker #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic busy_o,
    input logic mdc_o,
    input logic mdio_out_o,
    input logic mdio_oe_o
);
    logic        mdc_prev;
    logic [15:0] run_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_prev <= 1'b0;
            run_len  <= '0;
        end else begin
            mdc_prev <= mdc_o;
            run_len  <= (mdc_o != mdc_prev) ? 16'd0 : run_len + 16'd1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mdc_o && !mdio_oe_o && !mdio_out_o));

    assert_released_low_R11: assert property (@(posedge clk) disable iff (rst)
        !mdio_oe_o |-> !mdio_out_o);

    assert_high_len_R8: assert property (@(posedge clk) disable iff (rst)
        (mdc_prev && !mdc_o) |-> (run_len == 16'(HALF_DIV - 1)));

    assert_stable_high_R8: assert property (@(posedge clk) disable iff (rst)
        (mdc_o && mdc_prev) |-> ($stable(mdio_out_o) && $stable(mdio_oe_o)));

    assert_busy_entry_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind mdio_wr_master mdio_wr_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .mdc_o      (mdc_o),
    .mdio_out_o (mdio_out_o),
    .mdio_oe_o  (mdio_oe_o)
);

// File: tb/mdio_wr_master_tb.sv
module mdio_wr_master_tb;
    localparam int TB_DIV = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [4:0]  phy_addr_i;
    logic [4:0]  reg_addr_i;
    logic [15:0] wdata_i;
    logic        mdio_in_i;
    logic        mdc_o;
    logic        mdio_out_o;
    logic        mdio_oe_o;
    logic        busy_o;
    logic [64:0] capture_o;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    mdio_wr_master #(.HALF_DIV(TB_DIV)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .phy_addr_i (phy_addr_i),
        .reg_addr_i (reg_addr_i),
        .wdata_i    (wdata_i),
        .mdio_in_i  (mdio_in_i),
        .mdc_o      (mdc_o),
        .mdio_out_o (mdio_out_o),
        .mdio_oe_o  (mdio_oe_o),
        .busy_o     (busy_o),
        .capture_o  (capture_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic pat(input int i, input int seed);
        return (((i * 5) + seed) % 7) < 3;
    endfunction

    // Expected {oe, val} for bit i, computed from the frame layout
    function automatic logic [1:0] exp_line(input int i, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
        if (i < 32) return 2'b11;
        if (i < 36) return {1'b1, logic'(i % 2)};
        if (i < 41) return {1'b1, p[40 - i]};
        if (i < 46) return {1'b1, r[45 - i]};
        if (i < 48) return 2'b00;
        if (i < 64) return {1'b1, d[63 - i]};
        return 2'b00;
    endfunction

    function automatic string bit_req(input int i);
        if (i < 32) return "R2";
        if (i < 36) return "R3";
        if (i < 46) return "R4";
        if (i < 48) return "R5";
        if (i < 64) return "R6";
        return "R7";
    endfunction

    task automatic run_frame(input logic [4:0] p, input logic [4:0] r,
                             input logic [15:0] d, input int seed, input bit poke);
        int busy_cnt = 0;
        int rises = 0;
        logic prev = 1'b0;
        bit poked = 1'b0;
        logic [64:0] expc;
        logic [64:0] held;
        @(negedge clk);
        phy_addr_i = p;
        reg_addr_i = r;
        wdata_i    = d;
        start_i    = 1'b1;
        mdio_in_i  = pat(0, seed);
        @(negedge clk);
        start_i = 1'b0;
        check("R9 busy after start", 128'(busy_o), 128'(1));
        while (busy_o && busy_cnt < 100000) begin
            busy_cnt++;
            start_i = 1'b0;
            if (mdc_o && !prev) begin
                check(bit_req(rises), 128'({mdio_oe_o, mdio_out_o}),
                      128'(exp_line(rises, p, r, d)));
                rises++;
                mdio_in_i = pat(rises, seed);
            end
            prev = mdc_o;
            if (poke && rises == 10 && !poked) begin
                start_i    = 1'b1;
                phy_addr_i = ~p;
                reg_addr_i = ~r;
                wdata_i    = ~d;
                poked      = 1'b1;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check("R8 busy length", 128'(busy_cnt), 128'(130 * TB_DIV));
        check("R7 rise count", 128'(rises), 128'(65));
        for (int i = 0; i < 65; i++) expc[64 - i] = pat(i, seed);
        check("R10 capture", 128'(capture_o), 128'(expc));
        check("R1 idle lines", 128'({mdc_o, mdio_oe_o, mdio_out_o}), 128'(0));
        held = capture_o;
        for (int k = 0; k < 4; k++) begin
            mdio_in_i = ~mdio_in_i;
            @(negedge clk);
        end
        check("R10 capture held", 128'(capture_o), 128'(held));
        check("R1 idle after frame", 128'({busy_o, mdc_o, mdio_oe_o, mdio_out_o}), 128'(0));
    endtask

    initial begin
        rst        = 1'b1;
        start_i    = 1'b0;
        phy_addr_i = '0;
        reg_addr_i = '0;
        wdata_i    = '0;
        mdio_in_i  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset outputs", 128'({busy_o, mdc_o, mdio_oe_o, mdio_out_o}), 128'(0));
        check("R1 reset capture", 128'(capture_o), 128'(0));

        // R11 and R5/R7 released-bit checks happen at every frame bit
        run_frame(5'd0, 5'd0, 16'h0000, 1, 1'b0);
        run_frame(5'd31, 5'd31, 16'hFFFF, 2, 1'b0);
        for (int p = 0; p < 32; p++) begin
            run_frame(5'(p), 5'(31 - p), 16'((p * 2053) ^ 16'hA5C3), p + 3, 1'b0);
        end
        // R9: a start during a frame is ignored
        run_frame(5'h15, 5'h0A, 16'h1234, 4, 1'b1);
        run_frame(5'h0A, 5'h15, 16'h8001, 5, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule